// File: doc/BRIEF.md
# Dual-Channel Memory Fill Engine

This block clears or paints regions of memory with a constant 32-bit word, without involving a processor. It has two independent channels. Each channel is programmed through a small 32-bit register bus with a start address, an end address, a size word and a fill value. Writing the fill value is what launches the channel. The engine then streams one word per beat to a memory write port. The port uses a valid/ready handshake.

Addresses in the start and end registers count 8-byte units. The engine emits byte addresses on the write port, stepping by 4. Each emitted word is the programmed value with its byte order reversed. The two channels share one write port. Whichever channel first drives the port keeps it until its whole region is written, and only then can the other channel use it. Each channel reports a busy level and a one-cycle done pulse.

Top module: `dual_fill_engine`

## Requirements
- R1: Register offsets are as follows. Channel 0 occupies 0x10-0x1C and channel 1 occupies 0x20-0x2C. Within a channel, offset bits [3:2] select the register: 0 is start, 1 is end, 2 is size and 3 is value. Every register reads back the last value written to it, and any other offset reads 0.
- R2: Writing a value register while that channel is idle and its start register is non-zero launches a fill. Busy reads 1 from the next cycle.
- R3: Writing a value register while the channel's start register is 0 stores the value but produces no memory write, no busy and no done.
- R4: A fill writes consecutive words at byte addresses start*8, start*8+4, and so on, up to but not including end*8. The address bus is 35 bits wide, so the multiplication never wraps.
- R5: The size register has no effect on the range that is written.
- R6: Every word written equals the value captured at launch with its bytes reversed, so value bits [7:0] appear on data bits [31:24].
- R7: If end <= start at launch, no memory write occurs and done pulses in the cycle after the value write.
- R8: Once mem_valid is high, it stays high with mem_addr and mem_data unchanged until mem_ready is seen.
- R9: Busy stays high until the last word of the channel is accepted. Done is high for exactly the one cycle after that acceptance, and busy is low by then.
- R10: A channel that has begun driving the port keeps it until its last word is accepted. A channel launched meanwhile waits and then writes its whole region.
- R11: A value write to a busy channel updates the register but neither restarts nor alters the running fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mem_valid | output | 1 | Write beat offered |
| mem_addr | output | 32+UNIT_SH | Byte address of the beat |
| mem_data | output | 32 | Byte-reversed fill word |
| mem_ready | input | 1 | Memory accepts the beat |
| busy | output | 2 | Per-channel fill in progress |
| done | output | 2 | Per-channel one-cycle completion pulse |

## Verification
Fills are run with mem_ready held high and with a pseudo-random stall pattern. The first setting shows back-to-back addressing and the exact done timing. The second shows that beats hold steady under back-pressure. Regions are also launched with a zero start, with end equal to or below start, at the top of the 32-bit unit range, and with an odd size value. These cases separate the launch guard, the empty-range path, address width and the unused size field. Launching the second channel while the first owns the port, in both orders, shows that the port is kept, and a value rewrite during a busy fill shows that the running pattern is untouched.

// File: rtl/dual_fill_engine.sv
module dual_fill_engine #(
  parameter int RA_W    = 8,
  parameter int UNIT_SH = 3,
  localparam int AW     = 32 + UNIT_SH,
  localparam int PW     = AW - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_valid,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_data,
  input  logic            mem_ready,
  output logic [1:0]      busy,
  output logic [1:0]      done
);
  localparam int BW = RA_W - 4;

  logic [31:0]   r_start [2];
  logic [31:0]   r_end   [2];
  logic [31:0]   r_size  [2];
  logic [31:0]   r_val   [2];
  logic [PW-1:0] ptr     [2];
  logic [PW-1:0] lim     [2];
  logic [31:0]   pat     [2];
  logic [1:0]    busy_q, done_q, hit, go, empty;
  logic          lock_vld, lock_ch, sel, accept, last;

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      hit[c]   = reg_wr && (reg_addr[RA_W-1:4] == BW'(c + 1));
      go[c]    = hit[c] && (reg_addr[3:2] == 2'd3) && !busy_q[c] && (r_start[c] != 32'd0);
      empty[c] = r_end[c] <= r_start[c];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < 2; c++)
      if (reg_addr[RA_W-1:4] == BW'(c + 1))
        case (reg_addr[3:2])
          2'd0:    reg_rdata = r_start[c];
          2'd1:    reg_rdata = r_end[c];
          2'd2:    reg_rdata = r_size[c];
          default: reg_rdata = r_val[c];
        endcase
  end

  assign sel       = lock_vld ? lock_ch : ~busy_q[0];
  assign mem_valid = busy_q[sel];
  assign mem_addr  = {ptr[sel], 2'b00};
  assign mem_data  = pat[sel];
  assign accept    = mem_valid && mem_ready;
  assign last      = (ptr[sel] + PW'(1)) == lim[sel];
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        r_start[c] <= '0;
        r_end[c]   <= '0;
        r_size[c]  <= '0;
        r_val[c]   <= '0;
        ptr[c]     <= '0;
        lim[c]     <= '0;
        pat[c]     <= '0;
      end
      busy_q   <= '0;
      done_q   <= '0;
      lock_vld <= 1'b0;
      lock_ch  <= 1'b0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (hit[c])
          case (reg_addr[3:2])
            2'd0:    r_start[c] <= reg_wdata;
            2'd1:    r_end[c]   <= reg_wdata;
            2'd2:    r_size[c]  <= reg_wdata;
            default: r_val[c]   <= reg_wdata;
          endcase
        done_q[c] <= (go[c] && empty[c]) || (accept && sel == 1'(c) && last);
        if (go[c] && !empty[c]) begin
          busy_q[c] <= 1'b1;
          ptr[c]    <= PW'(r_start[c]) << (UNIT_SH - 2);
          lim[c]    <= PW'(r_end[c]) << (UNIT_SH - 2);
          pat[c]    <= swap32(reg_wdata);
        end else if (accept && sel == 1'(c)) begin
          ptr[c] <= ptr[c] + PW'(1);
          if (last) busy_q[c] <= 1'b0;
        end
      end
      if (accept && last) lock_vld <= 1'b0;
      else if (mem_valid) begin
        lock_vld <= 1'b1;
        lock_ch  <= sel;
      end
    end
  end

  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ptr[sel] < lim[sel]);

  a_r10_keep_port: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !(mem_ready && last) |=> mem_valid && sel == $past(sel));

  for (genvar g = 0; g < 2; g++) begin : g_chk
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_q[g] |-> !busy_q[g]);
    a_r11_pattern_kept: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q[g] && !(accept && sel == 1'(g) && last) |=> busy_q[g] && $stable(pat[g]));
  end
endmodule

// File: tb/dual_fill_engine_bench.sv
module dual_fill_engine_bench;
  localparam int AW = 35;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_valid, mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_data;
  logic [1:0] busy, done;

  int checks = 0, errors = 0;
  bit stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [68:0] sbq [$];
  logic [1:0] due_req = '0, due_now = '0;
  bit prev_stall = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [31:0] prev_data;

  dual_fill_engine u_dual_fill_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .busy(busy), .done(done));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = stall_mode ? lfsr[0] : 1'b1;
  end

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [1:0] nxt;
    logic [68:0] it;
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (due_now[c]) check(done[c] === 1'b1, "R9/R7 done pulse", done[c], 1);
        else if (done[c] !== 1'b0) check(0, "R9/R3 unexpected done", done[c], 0);
      end
      nxt = due_req;
      due_req = '0;
      if (prev_stall)
        check(mem_valid && mem_addr == prev_addr && mem_data == prev_data,
              "R8 beat held", {mem_addr, mem_data[28:0]}, {prev_addr, prev_data[28:0]});
      if (mem_valid && mem_ready) begin
        if (sbq.size() == 0) check(0, "R3/R11 unexpected write", mem_addr, 0);
        else begin
          it = sbq.pop_front();
          check(mem_addr == it[66:32], "R4/R10 address", mem_addr, it[66:32]);
          check(mem_data == it[31:0], "R6 data", mem_data, it[31:0]);
          if (it[68]) nxt[it[67]] = 1'b1;
        end
      end
      due_now = nxt;
      prev_stall = mem_valid && !mem_ready;
      prev_addr = mem_addr;
      prev_data = mem_data;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] due = 2'b00);
    @(posedge clk); #5;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    due_req = due_req | due;
    @(posedge clk); #5;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    @(posedge clk); #5;
    reg_addr = a; #1;
    check(reg_rdata === e, req, reg_rdata, e);
  endtask

  task automatic fill(input int ch, input logic [31:0] s, input logic [31:0] e,
                      input logic [31:0] sz, input logic [31:0] v, input bit runs);
    logic [7:0] b = 8'(16 * (ch + 1));
    logic [AW-1:0] a, lim;
    wr(b, s); wr(b + 8'h4, e); wr(b + 8'h8, sz);
    a = AW'(s) << 3; lim = AW'(e) << 3;
    if (runs && a < lim)
      for (logic [AW-1:0] p = a; p < lim; p += 4)
        sbq.push_back({(p + 4 == lim), 1'(ch), p, swap32(v)});
    wr(b + 8'hC, v, (runs && !(a < lim)) ? 2'(1 << ch) : 2'b00);
    if (runs && a < lim) check(busy[ch] === 1'b1, "R2 busy after launch", busy, 1 << ch);
  endtask

  task automatic wait_idle(input string req);
    while (sbq.size() != 0 || busy != 2'b00) @(negedge clk);
    repeat (3) @(negedge clk);
    check(busy === 2'b00 && sbq.size() == 0, req, busy, 0);
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
    check(busy === 2'b00 && done === 2'b00 && mem_valid === 1'b0, "R9 reset idle", {busy, done, mem_valid}, 0);
    rd(8'h1C, 32'h0, "R1 reset value reg");

    // R3: start left at zero, value write stores only
    wr(8'h14, 32'h0000_0200); wr(8'h18, 32'h0000_0055); wr(8'h1C, 32'hCAFE_0001);
    wr(8'h24, 32'h0000_0300); wr(8'h28, 32'h0000_0066); wr(8'h2C, 32'hCAFE_0002);
    repeat (4) @(negedge clk);
    check(busy === 2'b00, "R3 no fill with zero start", busy, 0);
    wr(8'h10, 32'h0000_0111); wr(8'h20, 32'h0000_0222);
    // R1 readback of all eight registers and unmapped offsets
    rd(8'h10, 32'h0000_0111, "R1 ch0 start"); rd(8'h14, 32'h0000_0200, "R1 ch0 end");
    rd(8'h18, 32'h0000_0055, "R1 ch0 size"); rd(8'h1C, 32'hCAFE_0001, "R3 ch0 value stored");
    rd(8'h20, 32'h0000_0222, "R1 ch1 start"); rd(8'h24, 32'h0000_0300, "R1 ch1 end");
    rd(8'h28, 32'h0000_0066, "R1 ch1 size"); rd(8'h2C, 32'hCAFE_0002, "R3 ch1 value stored");
    rd(8'h00, 32'h0, "R1 unmapped 0x00"); rd(8'h34, 32'h0, "R1 unmapped 0x34");
    check(busy === 2'b00, "R3 start writes do not launch", busy, 0);

    // R4 R5 R6 R9: plain fill, ready always high, odd size value
    fill(0, 32'h100, 32'h104, 32'hDEAD, 32'h1122_3344, 1);
    wait_idle("R9 ch0 idle after fill");
    // R8: stalled fill on channel 1
    stall_mode = 1'b1;
    fill(1, 32'h2000, 32'h2003, 32'h1, 32'hA5B6_C7D8, 1);
    wait_idle("R9 ch1 idle after stalled fill");
    // R7: equal and inverted bounds
    fill(0, 32'h50, 32'h50, 32'h0, 32'h0101_0101, 1);
    repeat (3) @(negedge clk);
    fill(1, 32'h60, 32'h10, 32'h40, 32'h0202_0202, 1);
    repeat (3) @(negedge clk);
    check(busy === 2'b00, "R7 empty range stays idle", busy, 0);
    // R10 R11: ch1 owns port, ch0 waits, rewrite of busy ch0 ignored
    fill(1, 32'h300, 32'h304, 32'h0, 32'h0BAD_F00D, 1);
    fill(0, 32'h400, 32'h402, 32'h0, 32'h1357_9BDF, 1);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'hFFFF_FFFF, "R11 value stored while busy");
    check(busy[0] === 1'b1, "R11 ch0 still busy", busy, 3);
    wait_idle("R10 both finish ch1 first");
    // R10: ch0 owns, ch1 waits
    fill(0, 32'h500, 32'h503, 32'h7, 32'h8899_AABB, 1);
    fill(1, 32'h600, 32'h601, 32'h7, 32'hCCDD_EEFF, 1);
    wait_idle("R10 both finish ch0 first");
    // R4: top of the unit range
    stall_mode = 1'b0;
    fill(0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0, 32'h7766_5544, 1);
    wait_idle("R4 wide address fill done");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule